// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Host Controller

This block is the host side of an Ultra DMA write burst on a 16-bit IDE-style disk bus. It waits in an idle state, passing the host's register-access chip selects and address lines through to the bus. When the device raises its DMA request, the block runs the opening handshake. It raises STOP and the host strobe, forces the chip selects and address lines quiet, and holds that for a programmable set-up interval. It then asserts the active-low acknowledge, and releases STOP after a second programmable interval.

Once the acknowledge is out, the block takes words from a valid/ready source and places each one on the data bus. The first negation of the host strobe waits for three things: the device's active-low ready line, a programmable data set-up time, and a programmable delay counted from when ready was first seen. After that, each further edge of the strobe, rising or falling, carries one new word. The edge is held back while ready is negated.

When the word marked last has been strobed, the block raises STOP. It keeps the acknowledge asserted until the device drops its request, then returns to idle. Before the first strobe negation, the block watches the device. If the device drops its request, or releases ready after asserting it, the block flags a protocol error.

Top module: `udma_out_host`

## Requirements
- R1: After reset and while idle, ack_n=1, stop=0, hstrobe=0, data_oe=0, data_out=0, src_ready=0, proto_err=0. cs0_n, cs1_n and addr follow pio_cs0_n, pio_cs1_n and pio_addr.
- R2: A burst starts only on a cycle where dev_req is sampled high in idle. The next cycle shows stop=1, hstrobe=1, cs0_n=cs1_n=1 and addr=0, with ack_n still 1. Those bus lines stay quiet until the return to idle, and dev_rdy_n has no effect while idle.
- R3: ack_n falls exactly span(cfg_setup_cyc) cycles after stop rises, where span(n) is n for n>0 and 1 for n=0.
- R4: Once low, ack_n stays low until the device drops dev_req after the final STOP.
- R5: stop falls exactly span(cfg_stop_cyc) cycles after ack_n falls, and never while ack_n is still high.
- R6: With acknowledge given and STOP released, src_ready is 1 whenever no word is waiting to be strobed and the last word has not been sent. A word accepted by src_valid && src_ready appears on data_out, with data_oe=1, in the following cycle.
- R7: The first hstrobe negation happens at the first clock edge where three conditions all hold. The word has been on the bus for at least span(cfg_dset_cyc) cycles. dev_rdy_n is sampled low. dev_rdy_n has been sampled low on at least span(cfg_rdy_cyc) consecutive earlier edges while ack_n was low.
- R8: Each later word toggles hstrobe once, in either direction, at the first edge with dev_rdy_n low and the word on the bus for span(cfg_dset_cyc) cycles. The number of strobe edges in a burst equals the number of words.
- R9: The cycle after the strobe edge carrying the src_last word, stop rises. When dev_req is then sampled low, the next cycle shows ack_n=1, stop=0, hstrobe=0, data_oe=0 and data_out=0.
- R10: proto_err is a one-cycle pulse, one cycle after a sampled violation. A violation is dev_req low, or dev_rdy_n high after it was seen low during the acknowledge, while a burst is open and the first strobe negation has not yet happened. It is never raised in a clean burst.
- R11: After the first word, hstrobe never changes on an edge where dev_rdy_n is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup_cyc | input | CW | Cycles of quiet bus before acknowledge |
| cfg_stop_cyc | input | CW | Cycles from acknowledge to STOP release |
| cfg_dset_cyc | input | CW | Data set-up cycles before a strobe edge |
| cfg_rdy_cyc | input | CW | Ready-to-first-strobe cycles |
| pio_cs0_n | input | 1 | Register-access chip select 0, passed through when idle |
| pio_cs1_n | input | 1 | Register-access chip select 1, passed through when idle |
| pio_addr | input | AW | Register-access address, passed through when idle |
| dev_req | input | 1 | Device DMA request, active high |
| dev_rdy_n | input | 1 | Device ready for data, active low |
| src_valid | input | 1 | Source word valid |
| src_data | input | DW | Source word |
| src_last | input | 1 | Source word is the last of the burst |
| src_ready | output | 1 | Block accepts the source word this cycle |
| ack_n | output | 1 | DMA acknowledge, active low |
| stop | output | 1 | STOP line, active high |
| hstrobe | output | 1 | Host strobe, asserted high |
| cs0_n | output | 1 | Bus chip select 0 |
| cs1_n | output | 1 | Bus chip select 1 |
| addr | output | AW | Bus address lines |
| data_out | output | DW | Data bus value |
| data_oe | output | 1 | Data bus drive enable |
| proto_err | output | 1 | Device handshake violation pulse |

## Verification
The bench attacks several corner cases of the opening handshake and the strobe timing. Zero-valued interval settings must still give a one-cycle span; a design that treated zero literally would acknowledge in the same cycle STOP rose. A ready line that bounces before the first strobe must restart the ready delay and raise the error flag; a design that kept the old count would strobe too early, and one that skipped the check would stay silent. Ready is also released for several cycles mid-burst and the source inserts gaps, which catches a strobe that moves without ready or without a fresh word. A one-word burst and a request that drops while the set-up interval is running check that STOP follows the last word and that the acknowledge is held until the device ends the burst.

// File: rtl/udma_out_pkg.sv
package udma_out_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PREP,
    PH_ACKD,
    PH_XFER,
    PH_TERM
  } udma_phase_e;

  // Effective length of a programmed interval: zero is treated as one cycle.
  function automatic int unsigned udma_span(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/udma_span_timer.sv
module udma_span_timer
  import udma_out_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] age,
  output logic          reached
);

  localparam logic [CW-1:0] AGE_MAX = '1;

  // age counts clock edges since the last restart (restart edge gives 1)
  always_ff @(posedge clk) begin
    if (!rst_n)              age <= '0;
    else if (clear)          age <= '0;
    else if (restart)        age <= CW'(1);
    else if (age != AGE_MAX) age <= age + CW'(1);
  end

  assign reached = (32'(age) >= udma_span(32'(limit)));

  AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (age == AGE_MAX) |=> (age == AGE_MAX) || (age <= CW'(1))); // R7

endmodule

// File: rtl/udma_proto_watch.sv
module udma_proto_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_strobe,
  input  logic in_ack,
  input  logic dev_req,
  input  logic dev_rdy_n,
  output logic proto_err
);

  logic rdy_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     rdy_seen_q <= 1'b0;
    else if (!pre_strobe)           rdy_seen_q <= 1'b0;
    else if (in_ack && !dev_rdy_n)  rdy_seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= pre_strobe && (!dev_req || (rdy_seen_q && dev_rdy_n));
  end

  AST_ERR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(pre_strobe)); // R10

endmodule

// File: rtl/udma_out_host.sv
module udma_out_host
  import udma_out_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup_cyc,
  input  logic [CW-1:0] cfg_stop_cyc,
  input  logic [CW-1:0] cfg_dset_cyc,
  input  logic [CW-1:0] cfg_rdy_cyc,
  input  logic          pio_cs0_n,
  input  logic          pio_cs1_n,
  input  logic [AW-1:0] pio_addr,
  input  logic          dev_req,
  input  logic          dev_rdy_n,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  input  logic          src_last,
  output logic          src_ready,
  output logic          ack_n,
  output logic          stop,
  output logic          hstrobe,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          proto_err
);

  udma_phase_e   phase_q;
  logic          ack_n_q, stop_q, hs_q, oe_q;
  logic          pend_q, first_q, word_last_q, sent_last_q;
  logic [DW-1:0] data_q;

  // named internal events
  logic          req_seen, setup_done, stop_done, take_word;
  logic          gate_ok, strobe_evt, end_req, close_evt;
  logic          in_ack, pre_strobe, quiet;
  logic          ph_restart, ph_clear, ph_reached, rdy_clear, rdy_reached;
  logic [CW-1:0] ph_limit, ph_age, rdy_age;

  assign in_ack     = (phase_q == PH_ACKD) || (phase_q == PH_XFER) || (phase_q == PH_TERM);
  assign pre_strobe = ((phase_q == PH_PREP) || (phase_q == PH_ACKD) || (phase_q == PH_XFER))
                      && !first_q;
  assign quiet      = (phase_q != PH_IDLE);

  assign req_seen   = (phase_q == PH_IDLE) && dev_req;
  assign setup_done = (phase_q == PH_PREP) && ph_reached;
  assign stop_done  = (phase_q == PH_ACKD) && ph_reached;
  assign src_ready  = (phase_q == PH_XFER) && !pend_q && !sent_last_q;
  assign take_word  = src_ready && src_valid;
  assign gate_ok    = pend_q && ph_reached && !dev_rdy_n && (first_q || rdy_reached);
  assign strobe_evt = (phase_q == PH_XFER) && gate_ok;
  assign end_req    = (phase_q == PH_XFER) && !pend_q && sent_last_q;
  assign close_evt  = (phase_q == PH_TERM) && !dev_req;

  // one shared interval timer: each phase uses it for its own minimum
  always_comb begin
    case (phase_q)
      PH_PREP: ph_limit = cfg_setup_cyc;
      PH_ACKD: ph_limit = cfg_stop_cyc;
      default: ph_limit = cfg_dset_cyc;
    endcase
  end

  assign ph_restart = req_seen || setup_done || take_word;
  assign ph_clear   = (phase_q == PH_IDLE) && !dev_req;

  udma_span_timer #(.CW(CW)) u_phase_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ph_restart),
    .clear   (ph_clear),
    .limit   (ph_limit),
    .age     (ph_age),
    .reached (ph_reached)
  );

  // consecutive ready samples while acknowledged
  assign rdy_clear = dev_rdy_n || !in_ack;

  udma_span_timer #(.CW(CW)) u_rdy_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .clear   (rdy_clear),
    .limit   (cfg_rdy_cyc),
    .age     (rdy_age),
    .reached (rdy_reached)
  );

  udma_proto_watch u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_strobe (pre_strobe),
    .in_ack     (in_ack),
    .dev_req    (dev_req),
    .dev_rdy_n  (dev_rdy_n),
    .proto_err  (proto_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      ack_n_q     <= 1'b1;
      stop_q      <= 1'b0;
      hs_q        <= 1'b0;
      oe_q        <= 1'b0;
      pend_q      <= 1'b0;
      first_q     <= 1'b0;
      word_last_q <= 1'b0;
      sent_last_q <= 1'b0;
      data_q      <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_seen) begin
          phase_q <= PH_PREP;
          stop_q  <= 1'b1;
          hs_q    <= 1'b1;
        end
        PH_PREP: if (setup_done) begin
          phase_q <= PH_ACKD;
          ack_n_q <= 1'b0;
        end
        PH_ACKD: if (stop_done) begin
          phase_q <= PH_XFER;
          stop_q  <= 1'b0;
        end
        PH_XFER: begin
          if (end_req) begin
            phase_q <= PH_TERM;
            stop_q  <= 1'b1;
          end else if (take_word) begin
            data_q      <= src_data;
            word_last_q <= src_last;
            pend_q      <= 1'b1;
            oe_q        <= 1'b1;
          end else if (strobe_evt) begin
            hs_q        <= ~hs_q;
            pend_q      <= 1'b0;
            first_q     <= 1'b1;
            sent_last_q <= word_last_q;
          end
        end
        PH_TERM: if (close_evt) begin
          phase_q     <= PH_IDLE;
          ack_n_q     <= 1'b1;
          stop_q      <= 1'b0;
          hs_q        <= 1'b0;
          oe_q        <= 1'b0;
          pend_q      <= 1'b0;
          first_q     <= 1'b0;
          word_last_q <= 1'b0;
          sent_last_q <= 1'b0;
          data_q      <= '0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ack_n    = ack_n_q;
  assign stop     = stop_q;
  assign hstrobe  = hs_q;
  assign data_oe  = oe_q;
  assign data_out = data_q;
  assign cs0_n    = quiet ? 1'b1 : pio_cs0_n;
  assign cs1_n    = quiet ? 1'b1 : pio_cs1_n;
  assign addr     = quiet ? '0   : pio_addr;

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop) && ack_n) |-> $past(dev_req)); // R2

  AST_QUIET_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> (stop && hstrobe && cs0_n && cs1_n && (addr == '0))); // R3

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && (phase_q != PH_TERM)) |=> !ack_n); // R4

  AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop) |-> !$past(ack_n)); // R5

  AST_STROBE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hstrobe) && !ack_n) |-> !$past(dev_rdy_n)); // R11

  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hstrobe) && !ack_n) |-> ($stable(data_out) && data_oe)); // R8

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (!$past(dev_req) && !stop && !hstrobe && !data_oe)); // R9

endmodule

// File: tb/udma_out_host_test.sv
module udma_out_host_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_setup_cyc, cfg_stop_cyc, cfg_dset_cyc, cfg_rdy_cyc;
  logic        pio_cs0_n, pio_cs1_n;
  logic [2:0]  pio_addr;
  logic        dev_req, dev_rdy_n;
  logic        src_valid, src_last;
  logic [15:0] src_data;
  logic        src_ready, ack_n, stop, hstrobe, cs0_n, cs1_n, data_oe, proto_err;
  logic [2:0]  addr;
  logic [15:0] data_out;

  always #4 clk = ~clk; // 125 MHz

  udma_out_host uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup_cyc(cfg_setup_cyc), .cfg_stop_cyc(cfg_stop_cyc),
    .cfg_dset_cyc(cfg_dset_cyc), .cfg_rdy_cyc(cfg_rdy_cyc),
    .pio_cs0_n(pio_cs0_n), .pio_cs1_n(pio_cs1_n), .pio_addr(pio_addr),
    .dev_req(dev_req), .dev_rdy_n(dev_rdy_n),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .src_ready(src_ready), .ack_n(ack_n), .stop(stop), .hstrobe(hstrobe),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr), .data_out(data_out),
    .data_oe(data_oe), .proto_err(proto_err)
  );

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  function automatic int spn(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- source and pio drivers ----------------
  int s_n = 0, s_idx = 0;
  bit s_gap = 0;

  always @(negedge clk) begin
    cyc++;
    src_valid = (s_idx < s_n) && !(s_gap && (cyc % 3 == 1));
    src_data  = 16'(16'hA5C3 ^ (s_idx * 16'h0131) ^ (s_n << 12));
    src_last  = (s_idx == s_n - 1);
    pio_cs0_n = cyc[0];
    pio_cs1_n = cyc[1];
    pio_addr  = cyc[4:2];
  end

  // ---------------- behavioural reference model ----------------
  int          m_phase;   // 0 idle,1 setup,2 acked,3 words,4 closing
  int          m_cnt, m_dcnt, m_rdyc;
  bit          m_ack_n, m_stop, m_hs, m_oe, m_pend, m_first, m_lastw, m_lastsent;
  bit          m_seen, m_err;
  logic [15:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_dcnt = 0; m_rdyc = 0;
      m_ack_n = 1; m_stop = 0; m_hs = 0; m_oe = 0; m_pend = 0; m_first = 0;
      m_lastw = 0; m_lastsent = 0; m_seen = 0; m_err = 0; m_data = '0;
    end else begin
      int  o_phase, o_rdyc;
      bit  o_first, o_seen, pre;
      o_phase = m_phase; o_rdyc = m_rdyc; o_first = m_first; o_seen = m_seen;
      pre   = (o_phase >= 1) && (o_phase <= 3) && !o_first;
      m_err = pre && (!dev_req || (o_seen && dev_rdy_n));
      if (!pre) m_seen = 0;
      else if (o_phase >= 2 && !dev_rdy_n) m_seen = 1;
      case (o_phase)
        0: if (dev_req) begin m_phase = 1; m_stop = 1; m_hs = 1; m_cnt = 0; end
        1: begin
          m_cnt++;
          if (m_cnt >= spn(cfg_setup_cyc)) begin m_ack_n = 0; m_phase = 2; m_cnt = 0; end
        end
        2: begin
          m_cnt++;
          if (m_cnt >= spn(cfg_stop_cyc)) begin m_stop = 0; m_phase = 3; end
        end
        3: begin
          if (!m_pend) begin
            if (m_lastsent) begin m_phase = 4; m_stop = 1; end
            else if (src_valid) begin
              m_data = src_data; m_lastw = src_last; m_pend = 1; m_oe = 1;
              m_dcnt = 0; s_idx++;
            end
          end else begin
            m_dcnt++;
            if (m_dcnt >= spn(cfg_dset_cyc) && !dev_rdy_n &&
                (m_first || o_rdyc >= spn(cfg_rdy_cyc))) begin
              m_hs = !m_hs; m_pend = 0; m_first = 1; m_lastsent = m_lastw;
            end
          end
        end
        default: if (!dev_req) begin
          m_phase = 0; m_ack_n = 1; m_stop = 0; m_hs = 0; m_oe = 0; m_pend = 0;
          m_first = 0; m_lastw = 0; m_lastsent = 0; m_data = '0;
        end
      endcase
      if (dev_rdy_n || o_phase < 2) m_rdyc = 0;
      else if (m_rdyc < 255) m_rdyc++;
    end
  end

  // ---------------- per-cycle comparison and port monitors ----------------
  bit p_stop = 0, p_ack_n = 1, p_hs = 0, p_rdy_n = 1;
  int stop_rise = 0, ack_fall = 0, toggles = 0, exp_words = 0, err_pulses = 0;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R4 ack_n",     ack_n,     m_ack_n);
      chk("R5 stop",      stop,      m_stop);
      chk("R7 hstrobe",   hstrobe,   m_hs);
      chk("R6 data_out",  data_out,  m_data);
      chk("R6 data_oe",   data_oe,   m_oe);
      chk("R6 src_ready", src_ready, (m_phase == 3) && !m_pend && !m_lastsent);
      chk("R10 proto_err", proto_err, m_err);
      chk("R2 cs0_n", cs0_n, (m_phase == 0) ? pio_cs0_n : 1'b1);
      chk("R2 cs1_n", cs1_n, (m_phase == 0) ? pio_cs1_n : 1'b1);
      chk("R2 addr",  addr,  (m_phase == 0) ? pio_addr  : 3'd0);
      if (proto_err) err_pulses++;
      if (stop && !p_stop && ack_n) stop_rise = cyc;
      if (!ack_n && p_ack_n) begin
        chk("R3 setup span", cyc - stop_rise, spn(cfg_setup_cyc));
        ack_fall = cyc;
        toggles  = 0;
      end
      if (!stop && p_stop && !ack_n)
        chk("R5 stop span", cyc - ack_fall, spn(cfg_stop_cyc));
      if (hstrobe != p_hs && !ack_n) begin
        toggles++;
        if (toggles > 1) chk("R11 strobe while not ready", p_rdy_n, 1'b0);
      end
      if (ack_n && !p_ack_n) chk("R8 strobe edges per burst", toggles, exp_words);
    end
    p_stop = stop; p_ack_n = ack_n; p_hs = hstrobe; p_rdy_n = dev_rdy_n;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // ---------------- device-side stimulus ----------------
  task automatic run_burst(input int n, input int su, input int sc, input int ds,
                           input int rd, input int rdy_wait, input bit stall,
                           input bit gap, input bit bounce, input bit glitch);
    @(negedge clk);
    cfg_setup_cyc = 8'(su); cfg_stop_cyc = 8'(sc);
    cfg_dset_cyc  = 8'(ds); cfg_rdy_cyc  = 8'(rd);
    s_n = n; s_idx = 0; s_gap = gap; exp_words = n;
    dev_req = 1'b1;
    if (glitch) begin
      @(negedge clk); @(negedge clk);
      dev_req = 1'b0;
      @(negedge clk);
      dev_req = 1'b1;
    end
    while (ack_n) @(negedge clk);
    while (stop) @(negedge clk);
    repeat (rdy_wait) @(negedge clk);
    if (bounce) begin
      dev_rdy_n = 1'b0; @(negedge clk);
      dev_rdy_n = 1'b1; @(negedge clk);
    end
    dev_rdy_n = 1'b0;
    if (stall) begin
      while (hstrobe) @(negedge clk);
      @(negedge clk);
      dev_rdy_n = 1'b1;
      repeat (4) @(negedge clk);
      dev_rdy_n = 1'b0;
    end
    while (!(stop && !ack_n)) @(negedge clk);
    repeat (2) @(negedge clk);
    dev_req = 1'b0;
    while (!ack_n) @(negedge clk);
    dev_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle after close", {stop, hstrobe, data_oe}, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0; dev_req = 1'b0; dev_rdy_n = 1'b1;
    cfg_setup_cyc = '0; cfg_stop_cyc = '0; cfg_dset_cyc = '0; cfg_rdy_cyc = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ack_n", ack_n, 1'b1);
    chk("R1 reset outputs", {stop, hstrobe, data_oe, src_ready, proto_err}, 5'b0);
    chk("R1 reset data_out", data_out, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // idle: ready line wiggles, no request -> nothing starts
    repeat (3) begin
      @(negedge clk); dev_rdy_n = 1'b0;
      @(negedge clk); dev_rdy_n = 1'b1;
    end
    chk("R2 no start without request", {ack_n, stop, hstrobe}, 3'b100);
    chk("R1 pio pass-through", {cs0_n, cs1_n, addr}, {pio_cs0_n, pio_cs1_n, pio_addr});

    run_burst(4, 3, 2, 1, 4, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    run_burst(3, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_burst(1, 1, 3, 2, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 no error in clean bursts", err_pulses, 0);
    run_burst(3, 5, 1, 2, 3, 0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R10 violations flagged", err_pulses, 2);
    run_burst(5, 2, 2, 3, 2, 3, 1'b1, 1'b1, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule